// File: doc/BRIEF.md
# Privileged Key Slot Store

This block holds a small set of secret keys in hardware registers, one key per slot, for a cryptographic engine to use. Firmware loads, invalidates and selects keys through a command interface, but no output of that interface ever carries a key value. A selected key goes only to the engine-facing key port, and only when the slot is valid and its privilege level is allowed under the store's current privilege level.

Each slot carries four attributes: a valid bit, a secure-mode bit, a two-bit privilege level and a lock bit. A locked slot cannot be replaced or invalidated until the next hardware reset. Results of an engine operation come back through a result port. They can be written into a slot, and the slot then inherits the source slot's secure mode and privilege. A result derived from a secure-mode slot is never returned to firmware: it is forced into the named destination slot instead.

While the debug-open input is high, every key is unavailable. Slot contents are wiped on the next clock edge, and every key-touching request is refused.

Top module: `kss_key_store`

## Requirements
- R1: After reset every slot is invalid with a zero key and a clear lock, `cur_priv` is 0, and `cmd_done`, `res_done`, `key_valid`, `fw_res_valid` are low with `key_data` and `fw_res_data` zero.
- R2: `key_data` is all-zero in every cycle in which `key_valid` is low, and no command or status output ever carries key bits.
- R3: A use request (op 4) on a valid slot whose privilege is numerically greater than or equal to `cur_priv` makes `key_valid` high for exactly the next cycle. In that cycle `key_data` is the slot key, `key_secure` is the slot's secure bit and the status is 0.
- R4: A use request on an invalid slot returns status 1, and one on a slot whose privilege is numerically below `cur_priv` returns status 2. In both cases `key_valid` stays low and `key_data` stays zero.
- R5: Set-privilege (op 3) with `cmd_priv` >= `cur_priv` updates `cur_priv` with status 0. A lower value returns status 6 and leaves `cur_priv` unchanged. Privilege 0 is the most privileged and 3 the least.
- R6: Load or invalidate aimed at a locked slot returns status 3 and leaves the slot's key and attributes unchanged. A lock is cleared only by hardware reset.
- R7: For a result from a valid non-secure source slot, `res_to_slot`=1 writes `res_data` into the unlocked destination with status 0. The destination becomes valid, unlocked and takes the source's secure bit and privilege. With `res_to_slot`=0 the data appears on `fw_res_data` with `fw_res_valid` high for the next cycle. A locked destination gives status 3, and an invalid source gives status 1.
- R8: A result from a secure-mode source with `res_to_slot`=0 is written into the destination slot instead, with status 4. `fw_res_valid` stays low and `fw_res_data` stays zero.
- R9: While `dbg_open` is high, `key_valid` is low and `key_data` is zero. Use, load, invalidate and result requests return status 5. Every slot is invalidated with a zero key on the next edge, so after debug closes a use of any earlier key returns status 1.
- R10: When a load or invalidate command and a result write target the same slot in the same cycle, the command takes effect and the result returns status 7.
- R11: Status codes are 0 ok, 1 invalid slot, 2 privilege denied, 3 locked, 4 redirected, 5 debug blocked, 6 privilege raise refused and 7 conflict. `cmd_done` and `res_done` pulse high in the cycle after the request is sampled, together with the matching status.
- R12: Op codes are 1 load, 2 invalidate, 3 set-privilege and 4 use. An accepted load stores `cmd_key` with `cmd_secure`, `cmd_priv` and `cmd_lock` and marks the slot valid. An accepted invalidate makes the slot unusable. Op codes 0 and 5 to 7 change nothing and return status 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dbg_open | input | 1 | Debug interface open; wipes and blocks all keys |
| cmd_valid | input | 1 | Command request strobe |
| cmd_op | input | 3 | Command op code |
| cmd_slot | input | 3 | Target slot of the command |
| cmd_key | input | 128 | Key value for a load |
| cmd_priv | input | 2 | Privilege for load or set-privilege |
| cmd_secure | input | 1 | Secure-mode bit for a load |
| cmd_lock | input | 1 | Lock bit for a load |
| cmd_done | output | 1 | Command completed (one cycle) |
| cmd_status | output | 3 | Command status code |
| cur_priv | output | 2 | Current store privilege level |
| key_valid | output | 1 | Key presented to the engine |
| key_data | output | 128 | Key value to the engine |
| key_secure | output | 1 | Secure-mode bit of the presented key |
| res_valid | input | 1 | Engine result strobe |
| res_src | input | 3 | Slot whose key produced the result |
| res_dst | input | 3 | Destination slot for a stored result |
| res_to_slot | input | 1 | 1 = store result in slot, 0 = return to firmware |
| res_data | input | 128 | Engine result value |
| res_done | output | 1 | Result handled (one cycle) |
| res_status | output | 3 | Result status code |
| fw_res_valid | output | 1 | Result returned to firmware |
| fw_res_data | output | 128 | Result value returned to firmware |

## Verification
The hardest case to reach is a command and an engine result that claim the same slot in one cycle. The bench sets up both request sets before a single edge, so that the load and the result write collide. It then reads the winner back through a later use request. The secure redirect is the next hardest. It needs a secure slot to be loaded first, and then a result marked for firmware that names that slot as source. The effect can only be seen afterwards, when the destination slot's key appears on the key port with the secure flag set. The debug wipe is checked the same way: debug is closed again and old keys are then requested, since the wiped registers have no port of their own.

// File: rtl/kss_pkg.sv
`timescale 1ns/1ps
package kss_pkg;
  localparam int PRIV_W = 2;

  // command op codes
  localparam logic [2:0] OP_LOAD    = 3'd1;
  localparam logic [2:0] OP_INVAL   = 3'd2;
  localparam logic [2:0] OP_SETPRIV = 3'd3;
  localparam logic [2:0] OP_USE     = 3'd4;

  typedef enum logic [2:0] {
    ST_OK       = 3'd0,
    ST_INVALID  = 3'd1,
    ST_PRIV     = 3'd2,
    ST_LOCKED   = 3'd3,
    ST_REDIRECT = 3'd4,
    ST_DEBUG    = 3'd5,
    ST_RAISE    = 3'd6,
    ST_CONFLICT = 3'd7
  } status_e;

  typedef struct packed {
    logic              valid;
    logic              secure;
    logic              lock;
    logic [PRIV_W-1:0] priv;
  } attr_t;
endpackage

// File: rtl/kss_slot.sv
`timescale 1ns/1ps
module kss_slot
  import kss_pkg::*;
#(
  parameter int KEY_W = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wipe_i,
  input  logic             wr_en_i,
  input  logic [KEY_W-1:0] wr_key_i,
  input  attr_t            wr_attr_i,
  input  logic             inv_en_i,
  output attr_t            attr_o,
  output logic [KEY_W-1:0] key_o
);
  attr_t            attr_q, attr_d;
  logic [KEY_W-1:0] key_q, key_d;
  logic             upd;

  always_comb begin
    upd    = wipe_i | wr_en_i | inv_en_i;
    attr_d = attr_q;
    key_d  = key_q;
    if (wipe_i) begin
      attr_d.valid = 1'b0;
      key_d        = '0;
    end else if (wr_en_i) begin
      attr_d = wr_attr_i;
      key_d  = wr_key_i;
    end else if (inv_en_i) begin
      attr_d.valid  = 1'b0;
      attr_d.secure = 1'b0;
      key_d         = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      attr_q <= '0;
      key_q  <= '0;
    end else if (upd) begin
      attr_q <= attr_d;
      key_q  <= key_d;
    end
  end

  assign attr_o = attr_q;
  assign key_o  = key_q;

  // R6: a lock never drops outside reset
  p_lock_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    attr_q.lock |=> attr_q.lock);

  // R6: a locked key changes only through the debug wipe
  p_locked_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (attr_q.lock && !wipe_i) |=> $stable(key_q));

  // R9: the debug wipe leaves the slot invalid and zeroed
  p_wipe_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wipe_i |=> (!attr_q.valid && key_q == '0));
endmodule

// File: rtl/kss_cmd_eval.sv
`timescale 1ns/1ps
module kss_cmd_eval
  import kss_pkg::*;
#(
  parameter int N_SLOTS = 8,
  localparam int SLOT_W = $clog2(N_SLOTS)
) (
  input  logic                valid_i,
  input  logic [2:0]          op_i,
  input  logic [SLOT_W-1:0]   slot_i,
  input  logic [PRIV_W-1:0]   priv_i,
  input  logic [PRIV_W-1:0]   cur_priv_i,
  input  logic                dbg_i,
  input  attr_t [N_SLOTS-1:0] attrs_i,
  output status_e             status_o,
  output logic                load_o,
  output logic                inval_o,
  output logic                priv_upd_o,
  output logic                grant_o
);
  always_comb begin
    status_o   = ST_OK;
    load_o     = 1'b0;
    inval_o    = 1'b0;
    priv_upd_o = 1'b0;
    grant_o    = 1'b0;
    if (valid_i) begin
      case (op_i)
        OP_LOAD: begin
          if (dbg_i)                      status_o = ST_DEBUG;
          else if (attrs_i[slot_i].lock)  status_o = ST_LOCKED;
          else                            load_o   = 1'b1;
        end
        OP_INVAL: begin
          if (dbg_i)                      status_o = ST_DEBUG;
          else if (attrs_i[slot_i].lock)  status_o = ST_LOCKED;
          else                            inval_o  = 1'b1;
        end
        OP_SETPRIV: begin
          if (priv_i < cur_priv_i)        status_o   = ST_RAISE;
          else                            priv_upd_o = 1'b1;
        end
        OP_USE: begin
          if (dbg_i)                                 status_o = ST_DEBUG;
          else if (!attrs_i[slot_i].valid)           status_o = ST_INVALID;
          else if (attrs_i[slot_i].priv < cur_priv_i) status_o = ST_PRIV;
          else                                       grant_o  = 1'b1;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/kss_res_eval.sv
`timescale 1ns/1ps
module kss_res_eval
  import kss_pkg::*;
#(
  parameter int N_SLOTS = 8,
  localparam int SLOT_W = $clog2(N_SLOTS)
) (
  input  logic                valid_i,
  input  logic [SLOT_W-1:0]   src_i,
  input  logic [SLOT_W-1:0]   dst_i,
  input  logic                to_slot_i,
  input  logic                dbg_i,
  input  logic                cmd_hit_i,
  input  attr_t [N_SLOTS-1:0] attrs_i,
  output status_e             status_o,
  output logic                wr_o,
  output attr_t               wr_attr_o,
  output logic                fw_pass_o
);
  always_comb begin
    status_o  = ST_OK;
    wr_o      = 1'b0;
    fw_pass_o = 1'b0;
    wr_attr_o.valid  = 1'b1;
    wr_attr_o.secure = attrs_i[src_i].secure;
    wr_attr_o.lock   = 1'b0;
    wr_attr_o.priv   = attrs_i[src_i].priv;
    if (valid_i) begin
      if (dbg_i)                                      status_o  = ST_DEBUG;
      else if (!attrs_i[src_i].valid)                 status_o  = ST_INVALID;
      else if (!to_slot_i && !attrs_i[src_i].secure)  fw_pass_o = 1'b1;
      else if (attrs_i[dst_i].lock)                   status_o  = ST_LOCKED;
      else if (cmd_hit_i)                             status_o  = ST_CONFLICT;
      else begin
        wr_o     = 1'b1;
        status_o = to_slot_i ? ST_OK : ST_REDIRECT;
      end
    end
  end
endmodule

// File: rtl/kss_key_store.sv
`timescale 1ns/1ps
module kss_key_store
  import kss_pkg::*;
#(
  parameter int N_SLOTS = 8,
  parameter int KEY_W   = 128,
  localparam int SLOT_W = $clog2(N_SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dbg_open,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [SLOT_W-1:0] cmd_slot,
  input  logic [KEY_W-1:0]  cmd_key,
  input  logic [PRIV_W-1:0] cmd_priv,
  input  logic              cmd_secure,
  input  logic              cmd_lock,
  output logic              cmd_done,
  output logic [2:0]        cmd_status,
  output logic [PRIV_W-1:0] cur_priv,
  output logic              key_valid,
  output logic [KEY_W-1:0]  key_data,
  output logic              key_secure,
  input  logic              res_valid,
  input  logic [SLOT_W-1:0] res_src,
  input  logic [SLOT_W-1:0] res_dst,
  input  logic              res_to_slot,
  input  logic [KEY_W-1:0]  res_data,
  output logic              res_done,
  output logic [2:0]        res_status,
  output logic              fw_res_valid,
  output logic [KEY_W-1:0]  fw_res_data
);
  attr_t [N_SLOTS-1:0] attrs;
  logic  [KEY_W-1:0]   slot_key [N_SLOTS];

  status_e cmd_st, res_st;
  logic    ld_en, inv_en, priv_en, grant;
  logic    res_wr, fw_pass, cmd_hit;
  attr_t   res_attr, cmd_attr;

  // ---------------- request evaluation ----------------
  kss_cmd_eval #(.N_SLOTS(N_SLOTS)) u_cmd (
    .valid_i    (cmd_valid),
    .op_i       (cmd_op),
    .slot_i     (cmd_slot),
    .priv_i     (cmd_priv),
    .cur_priv_i (cur_priv_q),
    .dbg_i      (dbg_open),
    .attrs_i    (attrs),
    .status_o   (cmd_st),
    .load_o     (ld_en),
    .inval_o    (inv_en),
    .priv_upd_o (priv_en),
    .grant_o    (grant)
  );

  assign cmd_hit = (ld_en | inv_en) && (cmd_slot == res_dst);

  kss_res_eval #(.N_SLOTS(N_SLOTS)) u_res (
    .valid_i   (res_valid),
    .src_i     (res_src),
    .dst_i     (res_dst),
    .to_slot_i (res_to_slot),
    .dbg_i     (dbg_open),
    .cmd_hit_i (cmd_hit),
    .attrs_i   (attrs),
    .status_o  (res_st),
    .wr_o      (res_wr),
    .wr_attr_o (res_attr),
    .fw_pass_o (fw_pass)
  );

  always_comb begin
    cmd_attr.valid  = 1'b1;
    cmd_attr.secure = cmd_secure;
    cmd_attr.lock   = cmd_lock;
    cmd_attr.priv   = cmd_priv;
  end

  // ---------------- slot array ----------------
  for (genvar g = 0; g < N_SLOTS; g++) begin : g_slot
    logic             cmd_sel, res_sel;
    logic             wr_en;
    logic [KEY_W-1:0] wr_key;
    attr_t            wr_attr;

    assign cmd_sel = (cmd_slot == SLOT_W'(g));
    assign res_sel = (res_dst == SLOT_W'(g));
    assign wr_en   = (ld_en && cmd_sel) || (res_wr && res_sel);
    assign wr_key  = (ld_en && cmd_sel) ? cmd_key : res_data;
    assign wr_attr = (ld_en && cmd_sel) ? cmd_attr : res_attr;

    kss_slot #(.KEY_W(KEY_W)) u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .wipe_i    (dbg_open),
      .wr_en_i   (wr_en),
      .wr_key_i  (wr_key),
      .wr_attr_i (wr_attr),
      .inv_en_i  (inv_en && cmd_sel),
      .attr_o    (attrs[g]),
      .key_o     (slot_key[g])
    );
  end

  // ---------------- state and output registers ----------------
  logic [PRIV_W-1:0] cur_priv_q, cur_priv_d;
  logic              cmd_done_q, res_done_q;
  logic [2:0]        cmd_st_q, res_st_q;
  logic              kv_q, kv_d, ksec_q, ksec_d;
  logic [KEY_W-1:0]  key_q, key_d;
  logic              fwv_q, fwv_d;
  logic [KEY_W-1:0]  fwd_q, fwd_d;

  always_comb begin
    cur_priv_d = priv_en ? cmd_priv : cur_priv_q;
    kv_d       = grant;
    key_d      = grant ? slot_key[cmd_slot] : '0;
    ksec_d     = grant & attrs[cmd_slot].secure;
    fwv_d      = fw_pass;
    fwd_d      = fw_pass ? res_data : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_priv_q <= '0;
    end else if (priv_en) begin
      cur_priv_q <= cur_priv_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_done_q <= 1'b0;
      cmd_st_q   <= ST_OK;
      res_done_q <= 1'b0;
      res_st_q   <= ST_OK;
      kv_q       <= 1'b0;
      key_q      <= '0;
      ksec_q     <= 1'b0;
      fwv_q      <= 1'b0;
      fwd_q      <= '0;
    end else begin
      cmd_done_q <= cmd_valid;
      cmd_st_q   <= cmd_st;
      res_done_q <= res_valid;
      res_st_q   <= res_st;
      kv_q       <= kv_d;
      key_q      <= key_d;
      ksec_q     <= ksec_d;
      fwv_q      <= fwv_d;
      fwd_q      <= fwd_d;
    end
  end

  assign cur_priv     = cur_priv_q;
  assign cmd_done     = cmd_done_q;
  assign cmd_status   = cmd_st_q;
  assign res_done     = res_done_q;
  assign res_status   = res_st_q;
  assign key_valid    = kv_q & ~dbg_open;
  assign key_data     = key_q & {KEY_W{~dbg_open}};
  assign key_secure   = ksec_q & ~dbg_open;
  assign fw_res_valid = fwv_q;
  assign fw_res_data  = fwd_q;

  // R2: no key bits on the engine port unless a key is presented
  p_idle_key_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !key_valid |-> key_data == '0);

  // R5: the current privilege only moves toward less privileged values
  p_priv_monotonic_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_priv_q != $past(cur_priv_q)) |-> (cur_priv_q > $past(cur_priv_q)));

  // R4: a slot below the current privilege never yields a key
  p_denied_no_key_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == OP_USE && attrs[cmd_slot].priv < cur_priv_q) |=> !key_valid);

  // R8: results from a secure source never reach firmware
  p_secure_no_fw_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && attrs[res_src].secure) |=> !fw_res_valid);

  // R11: every command is acknowledged in the following cycle
  p_done_follows_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> cmd_done);
endmodule

// File: tb/tb_kss_key_store.sv
`timescale 1ns/1ps
module tb_kss_key_store;
  localparam logic [2:0] OP_LOAD = 3'd1, OP_INVAL = 3'd2, OP_SETPRIV = 3'd3, OP_USE = 3'd4;
  localparam logic [127:0] K0 = 128'h00112233_44556677_8899aabb_ccddeeff;
  localparam logic [127:0] K1 = 128'h0f1e2d3c_4b5a6978_8796a5b4_c3d2e1f0;
  localparam logic [127:0] K2 = 128'hdeadbeef_01234567_89abcdef_cafef00d;
  localparam logic [127:0] K3 = 128'h13579bdf_2468ace0_fedcba98_76543210;
  localparam logic [127:0] K4 = 128'ha5a5a5a5_5a5a5a5a_c3c3c3c3_3c3c3c3c;
  localparam logic [127:0] KA = 128'h11111111_22222222_33333333_44444444;
  localparam logic [127:0] D1 = 128'h99990000_88881111_77772222_66663333;
  localparam logic [127:0] D2 = 128'h0badc0de_0badc0de_0badc0de_0badc0de;
  localparam logic [127:0] D3 = 128'hfeedface_feedface_feedface_feedface;

  logic clk = 1'b0;
  logic rst_n, dbg_open;
  logic cmd_valid; logic [2:0] cmd_op; logic [2:0] cmd_slot; logic [127:0] cmd_key;
  logic [1:0] cmd_priv; logic cmd_secure, cmd_lock;
  logic cmd_done; logic [2:0] cmd_status; logic [1:0] cur_priv;
  logic key_valid; logic [127:0] key_data; logic key_secure;
  logic res_valid; logic [2:0] res_src, res_dst; logic res_to_slot; logic [127:0] res_data;
  logic res_done; logic [2:0] res_status; logic fw_res_valid; logic [127:0] fw_res_data;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  kss_key_store dut (.*);

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    cmd_valid = 1'b0;
    res_valid = 1'b0;
  endtask

  task automatic set_cmd(input logic [2:0] op, input logic [2:0] slot, input logic [127:0] key,
                         input logic [1:0] priv, input logic sec, input logic lck);
    cmd_valid = 1'b1; cmd_op = op; cmd_slot = slot; cmd_key = key;
    cmd_priv = priv; cmd_secure = sec; cmd_lock = lck;
  endtask

  task automatic set_res(input logic [2:0] src, input logic [2:0] dst, input logic to_slot,
                         input logic [127:0] data);
    res_valid = 1'b1; res_src = src; res_dst = dst; res_to_slot = to_slot; res_data = data;
  endtask

  task automatic do_cmd(input logic [2:0] op, input logic [2:0] slot, input logic [127:0] key,
                        input logic [1:0] priv, input logic sec, input logic lck);
    set_cmd(op, slot, key, priv, sec, lck);
    step();
  endtask

  task automatic do_res(input logic [2:0] src, input logic [2:0] dst, input logic to_slot,
                        input logic [127:0] data);
    set_res(src, dst, to_slot, data);
    step();
  endtask

  // use request, then check status, valid and data in the following cycle
  task automatic use_chk(input string tag, input logic [2:0] slot, input logic [2:0] exp_st,
                         input logic [127:0] exp_key);
    do_cmd(OP_USE, slot, '0, 2'd0, 1'b0, 1'b0);
    chk({tag, " status"}, 128'(cmd_status), 128'(exp_st));
    chk({tag, " key_valid"}, 128'(key_valid), 128'(exp_st == 3'd0));
    chk({tag, " key_data"}, key_data, exp_key);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; dbg_open = 1'b0;
    cmd_valid = 1'b0; cmd_op = '0; cmd_slot = '0; cmd_key = '0; cmd_priv = '0;
    cmd_secure = 1'b0; cmd_lock = 1'b0;
    res_valid = 1'b0; res_src = '0; res_dst = '0; res_to_slot = 1'b0; res_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset_state();
    do_reset();
    chk("R1 cur_priv", 128'(cur_priv), 128'd0);
    chk("R1 cmd_done", 128'(cmd_done), 128'd0);
    chk("R1 res_done", 128'(res_done), 128'd0);
    chk("R1 key_valid", 128'(key_valid), 128'd0);
    chk("R1 key_data", key_data, '0);
    chk("R1 fw_res_valid", 128'(fw_res_valid), 128'd0);
    chk("R1 fw_res_data", fw_res_data, '0);
    for (int s = 0; s < 8; s++) use_chk("R1 R4 slot invalid after reset", 3'(s), 3'd1, '0);
  endtask

  task automatic t_load_use();
    do_reset();
    do_cmd(OP_LOAD, 3'd2, K2, 2'd1, 1'b0, 1'b0);
    chk("R11 load done", 128'(cmd_done), 128'd1);
    chk("R12 load status", 128'(cmd_status), 128'd0);
    chk("R2 no key after load", key_data, '0);
    step();
    chk("R11 done drops", 128'(cmd_done), 128'd0);
    use_chk("R3 use slot2", 3'd2, 3'd0, K2);
    chk("R3 key_secure", 128'(key_secure), 128'd0);
    step();
    chk("R3 one-cycle key_valid", 128'(key_valid), 128'd0);
    chk("R2 idle key_data", key_data, '0);
    do_cmd(3'd6, 3'd2, KA, 2'd3, 1'b1, 1'b1);
    chk("R12 unused op status", 128'(cmd_status), 128'd0);
    chk("R12 unused op priv", 128'(cur_priv), 128'd0);
    do_cmd(3'd0, 3'd2, KA, 2'd0, 1'b0, 1'b0);
    use_chk("R12 unused ops leave key", 3'd2, 3'd0, K2);
    do_cmd(OP_LOAD, 3'd2, KA, 2'd0, 1'b0, 1'b0);
    use_chk("R12 reload replaces", 3'd2, 3'd0, KA);
    do_cmd(OP_INVAL, 3'd2, '0, 2'd0, 1'b0, 1'b0);
    chk("R12 inval status", 128'(cmd_status), 128'd0);
    use_chk("R12 invalidated slot", 3'd2, 3'd1, '0);
  endtask

  task automatic t_priv();
    do_reset();
    do_cmd(OP_LOAD, 3'd3, K3, 2'd0, 1'b0, 1'b0);
    do_cmd(OP_LOAD, 3'd2, K2, 2'd2, 1'b0, 1'b0);
    do_cmd(OP_SETPRIV, 3'd0, '0, 2'd1, 1'b0, 1'b0);
    chk("R5 lower privilege ok", 128'(cmd_status), 128'd0);
    chk("R5 cur_priv now 1", 128'(cur_priv), 128'd1);
    use_chk("R4 slot priv 0 denied at 1", 3'd3, 3'd2, '0);
    use_chk("R4 slot priv 2 allowed at 1", 3'd2, 3'd0, K2);
    do_cmd(OP_SETPRIV, 3'd0, '0, 2'd0, 1'b0, 1'b0);
    chk("R5 raise refused", 128'(cmd_status), 128'd6);
    chk("R5 cur_priv kept", 128'(cur_priv), 128'd1);
    do_cmd(OP_SETPRIV, 3'd0, '0, 2'd3, 1'b0, 1'b0);
    chk("R5 to 3", 128'(cur_priv), 128'd3);
    use_chk("R4 slot priv 2 denied at 3", 3'd2, 3'd2, '0);
  endtask

  task automatic t_lock();
    do_reset();
    do_cmd(OP_LOAD, 3'd4, K4, 2'd0, 1'b0, 1'b1);
    chk("R6 locked load ok", 128'(cmd_status), 128'd0);
    do_cmd(OP_INVAL, 3'd4, '0, 2'd0, 1'b0, 1'b0);
    chk("R6 inval locked", 128'(cmd_status), 128'd3);
    do_cmd(OP_LOAD, 3'd4, KA, 2'd0, 1'b0, 1'b0);
    chk("R6 replace locked", 128'(cmd_status), 128'd3);
    use_chk("R6 locked key intact", 3'd4, 3'd0, K4);
    do_reset();
    use_chk("R6 reset clears slot", 3'd4, 3'd1, '0);
    do_cmd(OP_LOAD, 3'd4, KA, 2'd0, 1'b0, 1'b0);
    chk("R6 reset clears lock", 128'(cmd_status), 128'd0);
    do_cmd(OP_INVAL, 3'd4, '0, 2'd0, 1'b0, 1'b0);
    chk("R6 inval after unlock", 128'(cmd_status), 128'd0);
  endtask

  task automatic t_writeback();
    do_reset();
    do_cmd(OP_LOAD, 3'd1, K1, 2'd2, 1'b0, 1'b0);
    do_res(3'd1, 3'd5, 1'b1, D1);
    chk("R11 res_done", 128'(res_done), 128'd1);
    chk("R7 store status", 128'(res_status), 128'd0);
    chk("R7 no fw result", 128'(fw_res_valid), 128'd0);
    use_chk("R7 stored result", 3'd5, 3'd0, D1);
    chk("R7 inherits non-secure", 128'(key_secure), 128'd0);
    do_res(3'd1, 3'd0, 1'b0, D2);
    chk("R7 fw status", 128'(res_status), 128'd0);
    chk("R7 fw valid", 128'(fw_res_valid), 128'd1);
    chk("R7 fw data", fw_res_data, D2);
    step();
    chk("R7 fw valid one cycle", 128'(fw_res_valid), 128'd0);
    do_cmd(OP_LOAD, 3'd6, K3, 2'd3, 1'b0, 1'b1);
    do_res(3'd1, 3'd6, 1'b1, D3);
    chk("R7 locked dst", 128'(res_status), 128'd3);
    use_chk("R7 locked dst unchanged", 3'd6, 3'd0, K3);
    do_res(3'd3, 3'd7, 1'b1, D3);
    chk("R7 invalid source", 128'(res_status), 128'd1);
    use_chk("R7 dst untouched by invalid source", 3'd7, 3'd1, '0);
    do_cmd(OP_SETPRIV, 3'd0, '0, 2'd3, 1'b0, 1'b0);
    use_chk("R7 inherited priv 2", 3'd5, 3'd2, '0);
  endtask

  task automatic t_secure();
    do_reset();
    do_cmd(OP_LOAD, 3'd0, K0, 2'd1, 1'b1, 1'b0);
    do_res(3'd0, 3'd7, 1'b0, D1);
    chk("R8 redirect status", 128'(res_status), 128'd4);
    chk("R8 fw valid low", 128'(fw_res_valid), 128'd0);
    chk("R8 fw data zero", fw_res_data, '0);
    use_chk("R8 redirected key", 3'd7, 3'd0, D1);
    chk("R8 inherits secure", 128'(key_secure), 128'd1);
    do_res(3'd0, 3'd7, 1'b1, D2);
    chk("R7 secure store", 128'(res_status), 128'd0);
    do_cmd(OP_SETPRIV, 3'd0, '0, 2'd2, 1'b0, 1'b0);
    use_chk("R8 inherited priv 1", 3'd7, 3'd2, '0);
  endtask

  task automatic t_debug();
    do_reset();
    do_cmd(OP_LOAD, 3'd2, K2, 2'd0, 1'b0, 1'b0);
    dbg_open = 1'b1;
    use_chk("R9 use blocked", 3'd2, 3'd5, '0);
    do_cmd(OP_LOAD, 3'd3, K3, 2'd0, 1'b0, 1'b0);
    chk("R9 load blocked", 128'(cmd_status), 128'd5);
    do_cmd(OP_INVAL, 3'd2, '0, 2'd0, 1'b0, 1'b0);
    chk("R9 inval blocked", 128'(cmd_status), 128'd5);
    do_res(3'd2, 3'd5, 1'b1, D1);
    chk("R9 result blocked", 128'(res_status), 128'd5);
    dbg_open = 1'b0;
    use_chk("R9 wiped slot2", 3'd2, 3'd1, '0);
    use_chk("R9 no load slot3", 3'd3, 3'd1, '0);
    use_chk("R9 no write slot5", 3'd5, 3'd1, '0);
  endtask

  task automatic t_collide();
    do_reset();
    do_cmd(OP_LOAD, 3'd1, K1, 2'd0, 1'b0, 1'b0);
    set_cmd(OP_LOAD, 3'd5, KA, 2'd0, 1'b0, 1'b0);
    set_res(3'd1, 3'd5, 1'b1, D2);
    step();
    chk("R10 command wins", 128'(cmd_status), 128'd0);
    chk("R10 result conflict", 128'(res_status), 128'd7);
    use_chk("R10 slot holds command key", 3'd5, 3'd0, KA);
  endtask

  initial begin
    #4000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset_state();
    t_load_use();
    t_priv();
    t_lock();
    t_writeback();
    t_secure();
    t_debug();
    t_collide();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule